// File: doc/BRIEF.md
# Three-Entry Receive Message Queue

This block holds up to three received messages that have already been accepted by an upstream filter. Each message is a unit of identifier, control byte and eight data bytes. The filter stage presents a message together with a one-cycle write strobe. Software sees the oldest stored message on a read port with no added latency. Software then retires that message with a one-cycle release pulse.

A two-bit occupancy count shows how many messages the queue holds. There is also a sticky full flag and a sticky overrun flag, and each flag is cleared by pulsing its own clear input. A message can arrive when all three slots are taken. The policy input then decides what happens: either the most recently stored message is replaced, or the arriving message is thrown away. A controller with two receive paths would instantiate the block twice.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset, msg_count is 0, full_flag and ovr_flag are 0, and rd_valid is 0.
- R2: A write strobe with fewer than three messages stored, and no release in the same cycle, raises msg_count by one at the next clock edge. The count never exceeds three.
- R3: While msg_count is nonzero, rd_valid is 1 and the read port shows the oldest stored message in the same cycle. Messages come out in the order they were written.
- R4: A release pulse with msg_count nonzero frees the oldest message and lowers msg_count by one at the next clock edge.
- R5: A release pulse with msg_count equal to 0 is ignored. The count stays 0 and no later message is affected.
- R6: full_flag becomes 1 at the clock edge where msg_count reaches three.
- R7: A write strobe while three messages are stored, with no release in the same cycle, sets ovr_flag. msg_count stays 3.
- R8: With ovr_policy = 0 (discard), a message that arrives while the queue is full is dropped. The three stored messages are unchanged.
- R9: With ovr_policy = 1 (overwrite), a message that arrives while the queue is full replaces the newest stored message. The oldest two messages and the read order are kept.
- R10: A write and a release in the same cycle while full are handled as the release first and then the write. The oldest message leaves, the new one is appended, msg_count stays 3, and ovr_flag is not set.
- R11: A pulse on clr_full clears full_flag, and a pulse on clr_ovr clears ovr_flag. If a set condition and a clear happen in the same cycle, the set wins.
- R12: full_flag returns to 0 as soon as msg_count drops below three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Accepted message strobe from the filter stage |
| wr_ident | input | 32 | Identifier of the incoming message |
| wr_ctrl | input | 8 | Control byte of the incoming message |
| wr_data | input | 64 | Eight data bytes of the incoming message |
| ovr_policy | input | 1 | Policy when full: 1 overwrites the newest message, 0 discards the new one |
| rel_req | input | 1 | Release the oldest message |
| clr_full | input | 1 | Clear full_flag |
| clr_ovr | input | 1 | Clear ovr_flag |
| rd_valid | output | 1 | Read port holds a message |
| rd_ident | output | 32 | Identifier of the oldest message |
| rd_ctrl | output | 8 | Control byte of the oldest message |
| rd_data | output | 64 | Data bytes of the oldest message |
| msg_count | output | 2 | Number of stored messages |
| full_flag | output | 1 | Sticky full indication |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The assertions check every cycle that the count moves correctly on a write, on a release and on an ignored empty release. They also check the count bound, that rd_valid agrees with the count, that overrun is raised on a write into a full queue, that a combined write and release while full raises no overrun, that discard leaves the oldest message stable, and that full_flag drops whenever the count leaves three. The arrival order of the payloads, which slot the overwrite policy replaces, and the effect of the clear pulses can only be shown by the bench scenarios. Each scenario fills and drains the queue and compares every retired message with the one expected.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ID_W   = 32;
    localparam int CTRL_W = 8;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   ident;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } rxq_msg_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             rel_req,
    input  logic             ovr_policy,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             ovr_evt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wptr;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t s_d, s_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_LAST : p - 1'b1;
    endfunction

    logic             rel_ok;
    logic [CNT_W-1:0] cnt_after_rel;

    always_comb begin
        s_d           = s_q;
        wr_en         = 1'b0;
        wr_idx        = s_q.wptr;
        ovr_evt       = 1'b0;
        rel_ok        = rel_req && (s_q.cnt != '0);
        cnt_after_rel = s_q.cnt - CNT_W'(rel_ok);
        s_d.cnt       = cnt_after_rel;
        if (rel_ok) begin
            s_d.rptr = ptr_inc(s_q.rptr);
        end
        if (wr_valid) begin
            if (cnt_after_rel != CNT_FULL) begin
                wr_en    = 1'b1;
                s_d.wptr = ptr_inc(s_q.wptr);
                s_d.cnt  = cnt_after_rel + 1'b1;
            end else begin
                ovr_evt = 1'b1;
                if (ovr_policy) begin
                    wr_en  = 1'b1;
                    wr_idx = ptr_dec(s_q.wptr);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_idx  = s_q.rptr;
    assign cnt_q_o = s_q.cnt;
    assign cnt_d_o = s_d.cnt;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  rxq_msg_t         wr_msg,
    input  logic [PTR_W-1:0] rd_idx,
    output rxq_msg_t         rd_msg
);
    rxq_msg_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rxq_msg_t slot_d;

        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_d = wr_msg;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end
    end

    always_comb begin
        rd_msg = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == PTR_W'(i)) begin
                rd_msg = slot_q[i];
            end
        end
    end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             ovr_evt,
    input  logic             clr_full,
    input  logic             clr_ovr,
    output logic             full_flag,
    output logic             ovr_flag
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic full;
        logic ovr;
    } flg_t;

    flg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cnt_d != CNT_FULL) begin
            s_d.full = 1'b0;
        end else if (cnt_q != CNT_FULL) begin
            s_d.full = 1'b1;
        end else if (clr_full) begin
            s_d.full = 1'b0;
        end
        if (ovr_evt) begin
            s_d.ovr = 1'b1;
        end else if (clr_ovr) begin
            s_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full_flag = s_q.full;
    assign ovr_flag  = s_q.ovr;
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_ident,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovr_policy,
    input  logic              rel_req,
    input  logic              clr_full,
    input  logic              clr_ovr,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_ident,
    output logic [CTRL_W-1:0] rd_ctrl,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  msg_count,
    output logic              full_flag,
    output logic              ovr_flag
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             ovr_evt;
    rxq_msg_t         wr_msg;
    rxq_msg_t         rd_msg;

    assign wr_msg = '{ident: wr_ident, ctrl: wr_ctrl, data: wr_data};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .rel_req    (rel_req),
        .ovr_policy (ovr_policy),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .cnt_q_o    (cnt_q),
        .cnt_d_o    (cnt_d),
        .ovr_evt    (ovr_evt)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_msg (wr_msg),
        .rd_idx (rd_idx),
        .rd_msg (rd_msg)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .ovr_evt   (ovr_evt),
        .clr_full  (clr_full),
        .clr_ovr   (clr_ovr),
        .full_flag (full_flag),
        .ovr_flag  (ovr_flag)
    );

    assign msg_count = cnt_q;
    assign rd_valid  = (cnt_q != '0);
    assign rd_ident  = rd_msg.ident;
    assign rd_ctrl   = rd_msg.ctrl;
    assign rd_data   = rd_msg.data;
endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk #(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             ovr_policy,
    input logic             rel_req,
    input logic             rd_valid,
    input logic [31:0]      rd_ident,
    input logic [CNT_W-1:0] msg_count,
    input logic             full_flag,
    input logic             ovr_flag
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_count <= CNT_FULL);

    assert_count_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rel_req && msg_count != CNT_FULL) |=> (msg_count == $past(msg_count) + 1'b1));

    assert_valid_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (msg_count != '0));

    assert_release_decr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !wr_valid && msg_count != '0) |=> (msg_count == $past(msg_count) - 1'b1));

    assert_empty_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !wr_valid && msg_count == '0) |=> (msg_count == '0));

    assert_full_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rel_req && msg_count == CNT_FULL - 1'b1) |=> full_flag);

    assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rel_req && msg_count == CNT_FULL) |=> (ovr_flag && msg_count == CNT_FULL));

    assert_discard_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rel_req && !ovr_policy && msg_count == CNT_FULL) |=> $stable(rd_ident));

    assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rel_req && msg_count == CNT_FULL && !ovr_flag) |=> (!ovr_flag && msg_count == CNT_FULL));

    assert_full_auto_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_count != CNT_FULL) |-> !full_flag);
endmodule

bind rx_msg_fifo rx_msg_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .ovr_policy (ovr_policy),
    .rel_req    (rel_req),
    .rd_valid   (rd_valid),
    .rd_ident   (rd_ident),
    .msg_count  (msg_count),
    .full_flag  (full_flag),
    .ovr_flag   (ovr_flag)
);

// File: tb/test_rx_msg_fifo.sv
module test_rx_msg_fifo;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_ident = '0;
    logic [7:0]  wr_ctrl = '0;
    logic [63:0] wr_data = '0;
    logic        ovr_policy = 1'b0;
    logic        rel_req = 1'b0;
    logic        clr_full = 1'b0;
    logic        clr_ovr = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_ident;
    logic [7:0]  rd_ctrl;
    logic [63:0] rd_data;
    logic [1:0]  msg_count;
    logic        full_flag;
    logic        ovr_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_msg_fifo i_rx_msg_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ident(wr_ident),
        .wr_ctrl(wr_ctrl), .wr_data(wr_data), .ovr_policy(ovr_policy),
        .rel_req(rel_req), .clr_full(clr_full), .clr_ovr(clr_ovr),
        .rd_valid(rd_valid), .rd_ident(rd_ident), .rd_ctrl(rd_ctrl),
        .rd_data(rd_data), .msg_count(msg_count), .full_flag(full_flag),
        .ovr_flag(ovr_flag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_of(input logic [31:0] id);
        return id[7:0] ^ 8'hA5;
    endfunction

    function automatic logic [63:0] data_of(input logic [31:0] id);
        return {id, ~id};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        rel_req  = 1'b0;
        clr_full = 1'b0;
        clr_ovr  = 1'b0;
    endtask

    task automatic set_msg(input logic [31:0] id);
        wr_valid = 1'b1;
        wr_ident = id;
        wr_ctrl  = ctrl_of(id);
        wr_data  = data_of(id);
    endtask

    task automatic push(input logic [31:0] id);
        set_msg(id);
        tick();
    endtask

    task automatic pop_expect(input string req, input logic [31:0] id);
        check(req, 64'(rd_valid), 64'd1);
        check(req, 64'(rd_ident), 64'(id));
        check(req, 64'(rd_ctrl), 64'(ctrl_of(id)));
        check(req, rd_data, data_of(id));
        rel_req = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        check("R1 count", 64'(msg_count), 64'd0);
        check("R1 full", 64'(full_flag), 64'd0);
        check("R1 ovr", 64'(ovr_flag), 64'd0);
        check("R1 valid", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_fill_drain();
        push(32'h100);
        check("R2 count1", 64'(msg_count), 64'd1);
        check("R3 oldest", 64'(rd_ident), 64'h100);
        push(32'h101);
        push(32'h102);
        check("R2 count3", 64'(msg_count), 64'd3);
        check("R6 full", 64'(full_flag), 64'd1);
        pop_expect("R4 first", 32'h100);
        check("R4 count2", 64'(msg_count), 64'd2);
        check("R12 full drop", 64'(full_flag), 64'd0);
        pop_expect("R3 second", 32'h101);
        pop_expect("R3 third", 32'h102);
        check("R4 empty", 64'(msg_count), 64'd0);
        check("R3 invalid", 64'(rd_valid), 64'd0);
        rel_req = 1'b1;
        tick();
        check("R5 empty release", 64'(msg_count), 64'd0);
        push(32'h1AB);
        check("R5 after", 64'(rd_ident), 64'h1AB);
        pop_expect("R5 drain", 32'h1AB);
    endtask

    task automatic t_discard();
        ovr_policy = 1'b0;
        push(32'h200); push(32'h201); push(32'h202);
        push(32'h2FF);
        check("R7 count", 64'(msg_count), 64'd3);
        check("R7 ovr", 64'(ovr_flag), 64'd1);
        clr_ovr = 1'b1;
        tick();
        check("R11 ovr clr", 64'(ovr_flag), 64'd0);
        pop_expect("R8 a", 32'h200);
        pop_expect("R8 b", 32'h201);
        pop_expect("R8 c", 32'h202);
        check("R8 empty", 64'(msg_count), 64'd0);
    endtask

    task automatic t_overwrite();
        ovr_policy = 1'b1;
        push(32'h300); push(32'h301); push(32'h302);
        push(32'h3EE);
        check("R9 count", 64'(msg_count), 64'd3);
        check("R9 ovr", 64'(ovr_flag), 64'd1);
        clr_ovr = 1'b1;
        tick();
        pop_expect("R9 a", 32'h300);
        pop_expect("R9 b", 32'h301);
        pop_expect("R9 c", 32'h3EE);
        ovr_policy = 1'b0;
    endtask

    task automatic t_same_cycle();
        push(32'h400); push(32'h401); push(32'h402);
        set_msg(32'h403);
        rel_req = 1'b1;
        tick();
        check("R10 count", 64'(msg_count), 64'd3);
        check("R10 ovr", 64'(ovr_flag), 64'd0);
        pop_expect("R10 a", 32'h401);
        pop_expect("R10 b", 32'h402);
        pop_expect("R10 c", 32'h403);
    endtask

    task automatic t_clear();
        push(32'h500); push(32'h501); push(32'h502);
        check("R6 full set", 64'(full_flag), 64'd1);
        clr_full = 1'b1;
        tick();
        check("R11 full clr", 64'(full_flag), 64'd0);
        check("R11 count", 64'(msg_count), 64'd3);
        set_msg(32'h5FF);
        clr_ovr = 1'b1;
        tick();
        check("R11 set wins", 64'(ovr_flag), 64'd1);
        clr_ovr = 1'b1;
        tick();
        check("R11 ovr clr2", 64'(ovr_flag), 64'd0);
        pop_expect("R11 a", 32'h500);
        pop_expect("R11 b", 32'h501);
        pop_expect("R11 c", 32'h502);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_discard();
        t_overwrite();
        t_same_cycle();
        t_clear();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            if (done) break;
            @(posedge clk);
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule